// File: doc/BRIEF.md
# Rotating Operator Parameter Store

This block holds the per-operator parameters and running state of a time-multiplexed FM synthesis engine. It uses a recirculating shift ring instead of addressable RAM. Every clock is one operator slot. The entry at the tail of the ring is handed to a single shared operator pipeline. That pipeline returns an updated entry a fixed number of clocks later (`PIPE_LAT`), and the returned entry is pushed back in at the head. The ring, the pipeline's internal stages and the write-back path together form one loop that is exactly `NUM_CH*NUM_OP` entries long, so each entry comes back to the tail once per frame.

Storage has no random access. A host write to one field of one entry is parked as a single pending write. It is merged into that entry when the entry's write-back passes the head. Only the addressed field is replaced; the other fields take the pipeline's result. Two test controls freeze fields by suppressing their write-back: phase hold freezes the phase field and envelope hold freezes the attenuation field. While a hold is active, the circulating entry keeps the value it had when it was presented to the pipeline.

The data paths run at a fixed rate and have no back-pressure. The pipeline must accept `proc_entry` on every clock and must supply `wb_entry` on every clock, for the slot that was presented `PIPE_LAT` clocks earlier. The host port is never stalled. A newer write simply replaces one that has not yet committed.

Top module: `op_param_ring`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the outputs are as follows: `slot_idx` is 0, `frame_strobe` is 0, `wr_pending` is 0, and `proc_entry` is all zeros. All ring entries reset to zero.
- R2: `slot_idx` increases by one per clock and wraps from `NUM_CH*NUM_OP-1` to 0.
- R3: `frame_strobe` is high exactly in the cycles where `slot_idx` equals `NUM_CH*NUM_OP-1`, the last slot of a frame.
- R4: Suppose `proc_entry` is presented for slot s in cycle t, and no hold or commit applies to that slot. Then the `wb_entry` value driven in cycle t+`PIPE_LAT` is presented again as `proc_entry` for slot s in cycle t+`NUM_CH*NUM_OP`.
- R5: An accepted host write makes `wr_pending` high from the next cycle. It stays high until the write commits.
- R6: The slot of an entry is op*`NUM_CH`+ch. Field f occupies bits [f*`FIELD_W` +: `FIELD_W`]. A pending write to (ch, op, f) commits in the cycle that slot's write-back arrives, which is `PIPE_LAT` cycles after `slot_idx` equals that slot. On commit, field f takes `wr_data`, the other fields take `wb_entry`, and `wr_pending` drops, unless R11 applies.
- R7: A host write accepted while another write is pending replaces it. The replaced write never reaches the ring.
- R8: While `phase_hold` is high, field 0 (phase) of each written-back entry keeps the value it had when it was presented, whatever `wb_entry` carries.
- R9: While `env_hold` is high, field 1 (attenuation) of each written-back entry keeps its presented value.
- R10: A committing host write to field 0 or field 1 takes effect even while the corresponding hold is active.
- R11: If a host write is accepted in the same cycle as a commit, the earlier write commits and the new write becomes pending, so `wr_pending` stays high.
- R12: A host write is ignored if `wr_ch` is not below `NUM_CH`, or `wr_op` is not below `NUM_OP`, or `wr_field` is not below `NUM_FIELDS`. Ignored means no pending write is created and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one operator slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_idx | output | $clog2(NUM_CH*NUM_OP) | Slot of the entry at the tail |
| frame_strobe | output | 1 | High during the last slot of a frame |
| proc_entry | output | NUM_FIELDS*FIELD_W | Tail entry sent to the operator pipeline |
| wb_entry | input | NUM_FIELDS*FIELD_W | Pipeline result for the slot presented PIPE_LAT cycles ago |
| phase_hold | input | 1 | Suppress write-back of field 0 |
| env_hold | input | 1 | Suppress write-back of field 1 |
| wr_en | input | 1 | Host field write strobe |
| wr_ch | input | $clog2(NUM_CH) | Target channel |
| wr_op | input | $clog2(NUM_OP) | Target operator |
| wr_field | input | $clog2(NUM_FIELDS) | Target field index |
| wr_data | input | FIELD_W | New field value |
| wr_pending | output | 1 | A host write is waiting for its slot |

## Verification
The assertions check the per-cycle rules on every cycle. These are the slot step and wrap, the strobe being followed by slot 0, and the setting, replacing and clearing of the pending write. They also check that a held field at the head equals its presented copy, and that a committing write lands in its field even under a hold. Other properties only show up over whole scenarios and are left to the bench. These are the loop length of one frame, the choice of which slot a commit lands on, the same-cycle commit-and-write case, and the way holds and writes build up over several frames. The bench tracks these with its own model of every entry and of the external pipeline.

// File: rtl/fmring_pkg.sv
package fmring_pkg;
  // Field roles that the merge logic treats specially
  localparam int FLD_PHASE = 0;
  localparam int FLD_ATTN  = 1;
endpackage

// File: rtl/ring_slot_seq.sv
module ring_slot_seq #(
  parameter int NUM_SLOTS = 24,
  parameter int PIPE_LAT  = 2,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] head_slot,
  output logic              frame_strobe
);
  localparam logic [SLOT_W-1:0] LAST   = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [SLOT_W-1:0] LAT    = SLOT_W'(PIPE_LAT);
  localparam logic [SLOT_W-1:0] BACKUP = SLOT_W'(NUM_SLOTS - PIPE_LAT);

  always_ff @(posedge clk) begin
    if (!rst_n)              slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  // slot whose write-back arrives this cycle
  always_comb begin
    if (slot_q >= LAT) head_slot = slot_q - LAT;
    else               head_slot = slot_q + BACKUP;
  end

  assign frame_strobe = (slot_q == LAST);

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1));
  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == LAST) |=> (slot_q == '0));
  assert_strobe_then_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> (slot_q == '0));
endmodule

// File: rtl/ring_pend_write.sv
module ring_pend_write #(
  parameter int SLOT_W  = 5,
  parameter int FIDX_W  = 2,
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_accept,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  logic [FIDX_W-1:0]  wr_fld,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic [SLOT_W-1:0]  head_slot,
  output logic               pend_valid,
  output logic               commit,
  output logic [FIDX_W-1:0]  commit_fld,
  output logic [FIELD_W-1:0] commit_data
);
  logic [SLOT_W-1:0] pend_slot;

  assign commit = pend_valid && (head_slot == pend_slot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid  <= 1'b0;
      pend_slot   <= '0;
      commit_fld  <= '0;
      commit_data <= '0;
    end else if (wr_accept) begin
      pend_valid  <= 1'b1;
      pend_slot   <= wr_slot;
      commit_fld  <= wr_fld;
      commit_data <= wr_data;
    end else if (commit) begin
      pend_valid  <= 1'b0;
    end
  end

  assert_set_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> pend_valid);
  assert_hold_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !commit) |=> pend_valid);
  assert_clear_on_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_accept) |=> !pend_valid);
  assert_newest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (commit_data == $past(wr_data)) && (commit_fld == $past(wr_fld)));
endmodule

// File: rtl/ring_field_merge.sv
module ring_field_merge
  import fmring_pkg::*;
#(
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W    = 8,
  parameter int FIDX_W     = 2,
  localparam int ENT_W     = NUM_FIELDS * FIELD_W
) (
  input  logic [ENT_W-1:0]   wb_entry,
  input  logic [ENT_W-1:0]   old_entry,
  input  logic               phase_hold,
  input  logic               env_hold,
  input  logic               commit,
  input  logic [FIDX_W-1:0]  commit_fld,
  input  logic [FIELD_W-1:0] commit_data,
  output logic [ENT_W-1:0]   head_entry
);
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    logic hold_here;
    if (f == FLD_PHASE)     begin : g_ph assign hold_here = phase_hold; end
    else if (f == FLD_ATTN) begin : g_eg assign hold_here = env_hold;   end
    else                    begin : g_no assign hold_here = 1'b0;       end

    always_comb begin
      if (commit && (commit_fld == FIDX_W'(f)))
        head_entry[f*FIELD_W +: FIELD_W] = commit_data;
      else if (hold_here)
        head_entry[f*FIELD_W +: FIELD_W] = old_entry[f*FIELD_W +: FIELD_W];
      else
        head_entry[f*FIELD_W +: FIELD_W] = wb_entry[f*FIELD_W +: FIELD_W];
    end
  end
endmodule

// File: rtl/op_param_ring.sv
module op_param_ring
  import fmring_pkg::*;
#(
  parameter int NUM_CH     = 6,
  parameter int NUM_OP     = 4,
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_W    = 8,
  parameter int PIPE_LAT   = 2,
  localparam int NUM_SLOTS = NUM_CH * NUM_OP,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int OP_W      = (NUM_OP > 1) ? $clog2(NUM_OP) : 1,
  localparam int FIDX_W    = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int ENT_W     = NUM_FIELDS * FIELD_W,
  localparam int DEPTH     = NUM_SLOTS - PIPE_LAT
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [SLOT_W-1:0]  slot_idx,
  output logic               frame_strobe,
  output logic [ENT_W-1:0]   proc_entry,
  input  logic [ENT_W-1:0]   wb_entry,
  input  logic               phase_hold,
  input  logic               env_hold,
  input  logic               wr_en,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic [OP_W-1:0]    wr_op,
  input  logic [FIDX_W-1:0]  wr_field,
  input  logic [FIELD_W-1:0] wr_data,
  output logic               wr_pending
);
  logic [ENT_W-1:0]   stor  [DEPTH];
  logic [ENT_W-1:0]   old_q [PIPE_LAT];
  logic [ENT_W-1:0]   old_tail;
  logic [ENT_W-1:0]   head_entry;
  logic [SLOT_W-1:0]  head_slot;
  logic [SLOT_W-1:0]  wr_slot;
  logic               wr_ok;
  logic               wr_accept;
  logic               commit;
  logic [FIDX_W-1:0]  commit_fld;
  logic [FIELD_W-1:0] commit_data;

  assign wr_ok = (int'(wr_ch) < NUM_CH) && (int'(wr_op) < NUM_OP) &&
                 (int'(wr_field) < NUM_FIELDS);
  assign wr_accept = wr_en && wr_ok;
  assign wr_slot   = SLOT_W'(int'(wr_op) * NUM_CH + int'(wr_ch));

  ring_slot_seq #(.NUM_SLOTS(NUM_SLOTS), .PIPE_LAT(PIPE_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_q(slot_idx),
    .head_slot(head_slot), .frame_strobe(frame_strobe)
  );

  ring_pend_write #(.SLOT_W(SLOT_W), .FIDX_W(FIDX_W), .FIELD_W(FIELD_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept), .wr_slot(wr_slot),
    .wr_fld(wr_field), .wr_data(wr_data), .head_slot(head_slot),
    .pend_valid(wr_pending), .commit(commit), .commit_fld(commit_fld),
    .commit_data(commit_data)
  );

  ring_field_merge #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .FIDX_W(FIDX_W)) u_merge (
    .wb_entry(wb_entry), .old_entry(old_tail), .phase_hold(phase_hold),
    .env_hold(env_hold), .commit(commit), .commit_fld(commit_fld),
    .commit_data(commit_data), .head_entry(head_entry)
  );

  // ring body: head at index 0, tail at DEPTH-1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stor[i] <= '0;
    end else begin
      stor[0] <= head_entry;
      for (int i = 1; i < DEPTH; i++) stor[i] <= stor[i-1];
    end
  end

  // copy of the presented entry, aligned with its write-back (for holds)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PIPE_LAT; i++) old_q[i] <= '0;
    end else begin
      old_q[0] <= stor[DEPTH-1];
      for (int i = 1; i < PIPE_LAT; i++) old_q[i] <= old_q[i-1];
    end
  end

  assign old_tail   = old_q[PIPE_LAT-1];
  assign proc_entry = stor[DEPTH-1];

  assert_phase_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_hold && !(commit && commit_fld == FIDX_W'(FLD_PHASE))) |=>
    (stor[0][FLD_PHASE*FIELD_W +: FIELD_W] == $past(old_tail[FLD_PHASE*FIELD_W +: FIELD_W])));
  assert_attn_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (env_hold && !(commit && commit_fld == FIDX_W'(FLD_ATTN))) |=>
    (stor[0][FLD_ATTN*FIELD_W +: FIELD_W] == $past(old_tail[FLD_ATTN*FIELD_W +: FIELD_W])));
  assert_write_beats_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && commit_fld == FIDX_W'(FLD_PHASE)) |=>
    (stor[0][FLD_PHASE*FIELD_W +: FIELD_W] == $past(commit_data)));
  assert_bad_addr_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok && !wr_pending) |=> !wr_pending);
endmodule

// File: tb/tb_op_param_ring.sv
module tb_op_param_ring;
  localparam int CLK_P = 10;
  localparam int NCH = 6, NOP = 4, NF = 4, FW = 8, LAT = 2;
  localparam int N = NCH * NOP;
  localparam int EW = NF * FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    slot_idx;
  logic          frame_strobe;
  logic [EW-1:0] proc_entry;
  logic [EW-1:0] wb_entry = '0;
  logic          phase_hold = 1'b0, env_hold = 1'b0, wr_en = 1'b0;
  logic [2:0]    wr_ch = '0;
  logic [1:0]    wr_op = '0, wr_field = '0;
  logic [FW-1:0] wr_data = '0;
  logic          wr_pending;

  op_param_ring #(.NUM_CH(NCH), .NUM_OP(NOP), .NUM_FIELDS(NF), .FIELD_W(FW),
                  .PIPE_LAT(LAT)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R4";

  // bench model
  logic [EW-1:0] model [N];
  logic [EW-1:0] pipe_e [LAT];
  int            pipe_s [LAT];
  int            bslot;
  bit            mpend;
  int            mp_slot, mp_fld;
  logic [FW-1:0] mp_data;

  // vectors: [31:28] ch [27:24] op [23:20] field [19] phase_hold [18] env_hold
  //          [15:8] data [7:0] cycles to run afterwards
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    32'h0020_5A1E, 32'h5330_C31E, 32'h2108_771E, 32'h3214_991E,
    32'h101C_421E, 32'h4300_E11E, 32'h0230_101E, 32'h7000_AA1E };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [EW-1:0] xf(input logic [EW-1:0] e);
    logic [EW-1:0] r = e;
    r[0 +: FW]  = e[0 +: FW] + 8'd1;
    r[FW +: FW] = e[FW +: FW] + 8'd2;
    return r;
  endfunction

  // called just after a falling edge: check this cycle, drive the next edge
  task automatic tick(input bit w, input int ch, input int op, input int fld,
                      input logic [FW-1:0] d);
    logic [EW-1:0] old, nw;
    int hs;
    chk("R2", 64'(slot_idx), 64'(bslot));
    chk("R3", 64'(frame_strobe), 64'(bslot == N-1));
    chk("R5", 64'(wr_pending), 64'(mpend));
    chk(cur_req, 64'(proc_entry), 64'(model[bslot]));
    hs  = pipe_s[LAT-1];
    old = pipe_e[LAT-1];
    wb_entry = xf(old);
    nw = xf(old);
    if (phase_hold) nw[0 +: FW]  = old[0 +: FW];
    if (env_hold)   nw[FW +: FW] = old[FW +: FW];
    if (mpend && mp_slot == hs) begin
      nw[mp_fld*FW +: FW] = mp_data;
      mpend = 0;
    end
    model[hs] = nw;
    for (int i = LAT-1; i > 0; i--) begin
      pipe_e[i] = pipe_e[i-1];
      pipe_s[i] = pipe_s[i-1];
    end
    pipe_e[0] = model[bslot];
    pipe_s[0] = bslot;
    wr_en = w; wr_ch = 3'(ch); wr_op = 2'(op); wr_field = 2'(fld); wr_data = d;
    if (w && ch < NCH && op < NOP && fld < NF) begin
      mpend = 1; mp_slot = op*NCH + ch; mp_fld = fld; mp_data = d;
    end
    bslot = (bslot + 1) % N;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 8'h00);
  endtask

  task automatic run_until(input int s);
    while (bslot != s) tick(0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    for (int i = 0; i < LAT; i++) begin
      pipe_e[i] = '0;
      pipe_s[i] = N - 1 - i;
    end
    bslot = 0; mpend = 0; mp_slot = 0; mp_fld = 0; mp_data = '0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 64'(slot_idx), 64'd0);
    chk("R1", 64'(frame_strobe), 64'd0);
    chk("R1", 64'(wr_pending), 64'd0);
    chk("R1", 64'(proc_entry), 64'd0);
    rst_n = 1'b1;

    cur_req = "R4";  idle(2*N + 5);

    cur_req = "R8";  phase_hold = 1; idle(N + 6); phase_hold = 0;
    cur_req = "R9";  env_hold = 1;   idle(N + 6); env_hold = 0;
    cur_req = "R4";  idle(N);

    // vector walk: commits (R6), wrap slot, holds with writes (R10), bad address (R12)
    for (int v = 0; v < NV; v++) begin
      logic [31:0] e = VEC[v];
      cur_req = (e[19] || e[18]) ? "R10" : "R6";
      phase_hold = e[19]; env_hold = e[18];
      tick(1, int'(e[31:28]), int'(e[27:24]), int'(e[23:20]), e[15:8]);
      if (e[31:28] >= NCH) chk("R12", 64'(wr_pending), 64'd0);
      idle(int'(e[7:0]));
      phase_hold = 0; env_hold = 0;
    end
    cur_req = "R12"; idle(N);

    // R7: second write replaces the first before it commits
    cur_req = "R7";
    run_until(0);
    tick(1, 1, 1, 2, 8'h33);   // slot 7
    tick(1, 2, 1, 2, 8'h44);   // slot 8
    idle(N + 4);
    run_until(7);
    chk("R7", 64'(proc_entry[2*FW +: FW] == 8'h33), 64'd0);
    chk("R7", 64'(proc_entry), 64'(model[7]));
    idle(N);

    // R11: new write lands in the commit cycle of the old one
    cur_req = "R11";
    run_until(20);
    tick(1, 0, 0, 3, 8'h21);   // slot 0, commits when slot_idx == 2
    run_until(2);
    tick(1, 0, 2, 3, 8'h62);   // slot 12, accepted in the commit cycle
    chk("R11", 64'(wr_pending), 64'd1);
    idle(2*N);
    run_until(0);
    chk("R11", 64'(proc_entry[3*FW +: FW]), 64'h21);
    run_until(12);
    chk("R11", 64'(proc_entry[3*FW +: FW]), 64'h62);
    chk("R5", 64'(wr_pending), 64'd0);
    idle(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule